// File: doc/BRIEF.md
# Fetch Address Sequencer with Return Stack

This block produces the instruction fetch address for a small processor core. It holds a 13-bit program counter and an 8-entry return-address stack, plus a 5-bit upper-address holding register that software loads separately. Each cycle the core's decoder raises at most a few command strobes: advance, jump, call, low-byte write, return, return-from-interrupt and interrupt entry. The unit turns them into the next fetch address. When it leaves an interrupt handler it also raises a one-cycle pulse so that the interrupt-enable logic can turn interrupts back on.

The upper address bits never come from the instruction word. A jump or call takes its low 11 bits from the literal and its top 2 bits from the holding register. A low-byte write takes its top 5 bits from the holding register. A parameter sets the number of implemented program words, a power of two. Every address is reduced modulo that size, so targets above the implemented space wrap around. The stack is a ring with no overflow or underflow indication.

All outputs are registered. A strobe sampled at one rising edge is visible on the outputs after that edge.

Top module: `pc_seq_unit`

## Requirements
- R1: After reset the fetch address is 0000h, the re-enable pulse is low, the holding register is zero and the stack pointer is at its first slot.
- R2: With only the advance strobe, the address becomes (PC+1) mod IMPL_WORDS. With the default 4096 words, FFFh advances to 000h. The fetch address never exceeds IMPL_WORDS-1.
- R3: Jump loads {hold[4:3], lit[10:0]} mod IMPL_WORDS.
- R4: Call loads the same target as jump and pushes (PC+1) mod IMPL_WORDS onto the stack.
- R5: A low-byte write loads {hold[4:0], data[7:0]} mod IMPL_WORDS.
- R6: A write to the holding register takes effect from the following cycle. A jump, call or low-byte write in the same cycle uses the previous holding value.
- R7: Return loads the most recently pushed, not yet popped address (last in, first out).
- R8: The stack is a ring of 8 slots. A ninth push overwrites the oldest entry. Pops past the bottom wrap around to the top slot, with no error indication.
- R9: Interrupt entry pushes the current fetch address unchanged and loads 0004h.
- R10: Return-from-interrupt pops like return and drives int_reenable_o high for exactly the one cycle in which the popped address appears.
- R11: When several strobes are high, one command wins. The order from highest to lowest is: interrupt entry, return-from-interrupt, return, call, jump, low-byte write, advance. Only the winner changes the PC and the stack.
- R12: With no command strobe the fetch address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance to the next sequential word |
| jump_i | input | 1 | Jump to the literal target |
| call_i | input | 1 | Call the literal target, saving the return address |
| pcl_wr_i | input | 1 | Computed write of the low PC byte |
| pcl_data_i | input | 8 | Data for the low-byte write |
| lit_i | input | 11 | Jump or call literal |
| ret_i | input | 1 | Return, also used for return-with-literal |
| reti_i | input | 1 | Return from interrupt |
| irq_take_i | input | 1 | Enter the interrupt vector |
| hold_wr_i | input | 1 | Write the upper-address holding register |
| hold_data_i | input | 5 | Data for the holding register |
| fetch_addr_o | output | 13 | Current fetch address |
| int_reenable_o | output | 1 | One-cycle pulse on return from interrupt |

## Verification
A holding-register write can land in the same cycle as a jump, call or low-byte write. A directed case writes the holding register together with a jump and expects the old upper bits, then expects the new bits on the next jump. The random phase raises all strobes at once at high rates, so interrupt entry collides with returns and calls. A bench reference model judges each of these cycles. It tracks its own stack ring and applies the stated priority order.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

   typedef enum logic [2:0] {
      CMD_IDLE  = 3'd0,
      CMD_ADV   = 3'd1,
      CMD_PCL   = 3'd2,
      CMD_JUMP  = 3'd3,
      CMD_CALL  = 3'd4,
      CMD_RET   = 3'd5,
      CMD_RETI  = 3'd6,
      CMD_IRQ   = 3'd7
   } pcu_cmd_e;

   function automatic logic cmd_pushes(input pcu_cmd_e c);
      return (c == CMD_CALL) || (c == CMD_IRQ);
   endfunction

   function automatic logic cmd_pops(input pcu_cmd_e c);
      return (c == CMD_RET) || (c == CMD_RETI);
   endfunction

endpackage

// File: rtl/pcu_cmd_arb.sv
module pcu_cmd_arb
   import pcu_pkg::*;
(
   input  logic     adv,
   input  logic     jump,
   input  logic     call,
   input  logic     pcl_wr,
   input  logic     ret,
   input  logic     reti,
   input  logic     irq,
   output pcu_cmd_e cmd
);

   always_comb begin
      if (irq)         cmd = CMD_IRQ;
      else if (reti)   cmd = CMD_RETI;
      else if (ret)    cmd = CMD_RET;
      else if (call)   cmd = CMD_CALL;
      else if (jump)   cmd = CMD_JUMP;
      else if (pcl_wr) cmd = CMD_PCL;
      else if (adv)    cmd = CMD_ADV;
      else             cmd = CMD_IDLE;
   end

endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
   parameter int DEPTH = 8,
   parameter int W     = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] push_data,
   output logic [W-1:0] top_data
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("pcu_ret_stack: DEPTH must be a power of two");
   end

   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [W-1:0]     slot [DEPTH];

   assign rd_ptr   = wr_ptr - 1'b1;
   assign top_data = slot[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wr_ptr <= '0;
      else if (push) wr_ptr <= wr_ptr + 1'b1;
      else if (pop)  wr_ptr <= wr_ptr - 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[i] <= '0;
         else if (push && (wr_ptr == PTR_W'(i)))
            slot[i] <= push_data;
      end
   end

   // R8: pointer moves one step per push and wraps around the ring
   p_ring_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> wr_ptr == PTR_W'($past(wr_ptr) + 1'b1));
   // R7: a pop steps the pointer back by one
   p_ring_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> wr_ptr == PTR_W'($past(wr_ptr) - 1'b1));
   // R4: the pushed value becomes the top entry
   p_push_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> top_data == $past(push_data));

endmodule

// File: rtl/pcu_next_addr.sv
module pcu_next_addr
   import pcu_pkg::*;
#(
   parameter int PC_W       = 13,
   parameter int HOLD_W     = 5,
   parameter int LIT_W      = 11,
   parameter int IMPL_WORDS = 4096,
   parameter int IRQ_VEC    = 4
) (
   input  pcu_cmd_e          cmd,
   input  logic [PC_W-1:0]   pc,
   input  logic [HOLD_W-1:0] hold,
   input  logic [LIT_W-1:0]  lit,
   input  logic [PC_W-HOLD_W-1:0] pcl_data,
   input  logic [PC_W-1:0]   pop_data,
   output logic [PC_W-1:0]   next_pc,
   output logic              push_en,
   output logic              pop_en,
   output logic [PC_W-1:0]   push_data
);

   localparam int TOP_W = PC_W - LIT_W;
   localparam logic [PC_W-1:0] ADDR_MASK = PC_W'(IMPL_WORDS - 1);

   logic [PC_W-1:0] raw_pc;
   logic [PC_W-1:0] seq_pc;
   logic [PC_W-1:0] lit_tgt;
   logic [PC_W-1:0] pcl_tgt;

   assign seq_pc  = pc + 1'b1;
   assign lit_tgt = {hold[HOLD_W-1 -: TOP_W], lit};
   assign pcl_tgt = {hold, pcl_data};

   always_comb begin
      unique case (cmd)
         CMD_ADV:  raw_pc = seq_pc;
         CMD_PCL:  raw_pc = pcl_tgt;
         CMD_JUMP,
         CMD_CALL: raw_pc = lit_tgt;
         CMD_RET,
         CMD_RETI: raw_pc = pop_data;
         CMD_IRQ:  raw_pc = PC_W'(IRQ_VEC);
         default:  raw_pc = pc;
      endcase
   end

   if (IMPL_WORDS == (1 << PC_W)) begin : g_full_space
      assign next_pc   = raw_pc;
      assign push_data = (cmd == CMD_IRQ) ? pc : seq_pc;
   end else begin : g_wrapped_space
      assign next_pc   = raw_pc & ADDR_MASK;
      assign push_data = (cmd == CMD_IRQ) ? pc : (seq_pc & ADDR_MASK);
   end

   assign push_en = cmd_pushes(cmd);
   assign pop_en  = cmd_pops(cmd);

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
   import pcu_pkg::*;
#(
   parameter int PC_W        = 13,
   parameter int HOLD_W      = 5,
   parameter int LIT_W       = 11,
   parameter int STACK_DEPTH = 8,
   parameter int IMPL_WORDS  = 4096,
   parameter int RESET_VEC   = 0,
   parameter int IRQ_VEC     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   adv_i,
   input  logic                   jump_i,
   input  logic                   call_i,
   input  logic                   pcl_wr_i,
   input  logic [PC_W-HOLD_W-1:0] pcl_data_i,
   input  logic [LIT_W-1:0]       lit_i,
   input  logic                   ret_i,
   input  logic                   reti_i,
   input  logic                   irq_take_i,
   input  logic                   hold_wr_i,
   input  logic [HOLD_W-1:0]      hold_data_i,
   output logic [PC_W-1:0]        fetch_addr_o,
   output logic                   int_reenable_o
);

   localparam logic [PC_W-1:0] ADDR_MASK = PC_W'(IMPL_WORDS - 1);

   if ((IMPL_WORDS & (IMPL_WORDS - 1)) != 0 || IMPL_WORDS > (1 << PC_W)
       || IMPL_WORDS < 2) begin : g_bad_words
      $error("pc_seq_unit: IMPL_WORDS must be a power of two within the PC range");
   end
   if (LIT_W >= PC_W || HOLD_W < PC_W - LIT_W || HOLD_W >= PC_W) begin : g_bad_fields
      $error("pc_seq_unit: literal and holding widths do not fit the PC");
   end
   if (IRQ_VEC >= IMPL_WORDS || RESET_VEC >= IMPL_WORDS) begin : g_bad_vec
      $error("pc_seq_unit: vectors must lie inside the implemented space");
   end

   pcu_cmd_e          cmd;
   logic [PC_W-1:0]   pc_q;
   logic [PC_W-1:0]   pc_d;
   logic [HOLD_W-1:0] hold_q;
   logic              reen_q;
   logic              push_en;
   logic              pop_en;
   logic [PC_W-1:0]   push_data;
   logic [PC_W-1:0]   pop_data;

   pcu_cmd_arb u_arb (
      .adv    (adv_i),
      .jump   (jump_i),
      .call   (call_i),
      .pcl_wr (pcl_wr_i),
      .ret    (ret_i),
      .reti   (reti_i),
      .irq    (irq_take_i),
      .cmd    (cmd)
   );

   pcu_next_addr #(
      .PC_W       (PC_W),
      .HOLD_W     (HOLD_W),
      .LIT_W      (LIT_W),
      .IMPL_WORDS (IMPL_WORDS),
      .IRQ_VEC    (IRQ_VEC)
   ) u_next (
      .cmd       (cmd),
      .pc        (pc_q),
      .hold      (hold_q),
      .lit       (lit_i),
      .pcl_data  (pcl_data_i),
      .pop_data  (pop_data),
      .next_pc   (pc_d),
      .push_en   (push_en),
      .pop_en    (pop_en),
      .push_data (push_data)
   );

   pcu_ret_stack #(
      .DEPTH (STACK_DEPTH),
      .W     (PC_W)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_en),
      .pop       (pop_en),
      .push_data (push_data),
      .top_data  (pop_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= PC_W'(RESET_VEC);
         hold_q <= '0;
         reen_q <= 1'b0;
      end else begin
         pc_q   <= pc_d;
         reen_q <= (cmd == CMD_RETI);
         if (hold_wr_i) hold_q <= hold_data_i;
      end
   end

   assign fetch_addr_o   = pc_q;
   assign int_reenable_o = reen_q;

   // R9: interrupt entry always lands on the vector
   p_irq_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take_i |=> fetch_addr_o == PC_W'(IRQ_VEC));
   // R12: no strobe keeps the address
   p_idle_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(adv_i || jump_i || call_i || pcl_wr_i || ret_i || reti_i || irq_take_i)
      |=> $stable(fetch_addr_o));
   // R10: re-enable pulse follows a winning return-from-interrupt
   p_reenable_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !irq_take_i) |=> int_reenable_o);
   // R10: no pulse without a winning return-from-interrupt
   p_reenable_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reti_i && !irq_take_i) |=> !int_reenable_o);
   // R2: sequential advance with wrap
   p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !(jump_i || call_i || pcl_wr_i || ret_i || reti_i || irq_take_i))
      |=> fetch_addr_o == PC_W'(($past(fetch_addr_o) + 1'b1) & ADDR_MASK));
   // R2: address stays in the implemented space
   p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_addr_o & ~ADDR_MASK) == '0);

endmodule

// File: tb/pc_seq_unit_tb_top.sv
module pc_seq_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int MASK       = 4095;
   localparam int DEPTH      = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv_i = 0, jump_i = 0, call_i = 0, pcl_wr_i = 0;
   logic        ret_i = 0, reti_i = 0, irq_take_i = 0, hold_wr_i = 0;
   logic [7:0]  pcl_data_i = '0;
   logic [10:0] lit_i = '0;
   logic [4:0]  hold_data_i = '0;
   logic [12:0] fetch_addr_o;
   logic        int_reenable_o;

   int checks = 0;
   int fails  = 0;

   int m_pc, m_hold, m_ptr;
   int m_stk [DEPTH];
   logic m_reen;

   always #(CLK_PERIOD/2) clk = ~clk;

   pc_seq_unit dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .adv_i          (adv_i),
      .jump_i         (jump_i),
      .call_i         (call_i),
      .pcl_wr_i       (pcl_wr_i),
      .pcl_data_i     (pcl_data_i),
      .lit_i          (lit_i),
      .ret_i          (ret_i),
      .reti_i         (reti_i),
      .irq_take_i     (irq_take_i),
      .hold_wr_i      (hold_wr_i),
      .hold_data_i    (hold_data_i),
      .fetch_addr_o   (fetch_addr_o),
      .int_reenable_o (int_reenable_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic void m_push(input int v);
      m_stk[m_ptr] = v;
      m_ptr = (m_ptr + 1) % DEPTH;
   endfunction

   function automatic int m_pop();
      m_ptr = (m_ptr + DEPTH - 1) % DEPTH;
      return m_stk[m_ptr];
   endfunction

   // one cycle: drive at negedge, update model, compare after the edge
   task automatic step(input logic a, j, c, p, r, ri, iq, hw,
                       input int pd, input int lt, input int hd, input string req);
      int top;
      @(negedge clk);
      adv_i = a; jump_i = j; call_i = c; pcl_wr_i = p;
      ret_i = r; reti_i = ri; irq_take_i = iq; hold_wr_i = hw;
      pcl_data_i = pd[7:0]; lit_i = lt[10:0]; hold_data_i = hd[4:0];
      m_reen = 1'b0;
      if (iq) begin m_push(m_pc); m_pc = 4; end
      else if (ri) begin m_pc = m_pop(); m_reen = 1'b1; end
      else if (r) m_pc = m_pop();
      else if (c) begin
         m_push((m_pc + 1) & MASK);
         m_pc = ((((m_hold >> 3) & 3) << 11) | (lt & 'h7FF)) & MASK;
      end
      else if (j) m_pc = ((((m_hold >> 3) & 3) << 11) | (lt & 'h7FF)) & MASK;
      else if (p) m_pc = ((m_hold << 8) | (pd & 'hFF)) & MASK;
      else if (a) m_pc = (m_pc + 1) & MASK;
      if (hw) m_hold = hd & 'h1F;
      top = m_pc;
      @(posedge clk);
      #1;
      check(req, int'(fetch_addr_o), top);
      check({req, " reenable R10"}, int'(int_reenable_o), int'(m_reen));
   endtask

   task automatic idle(input string req);
      step(0,0,0,0,0,0,0,0, 0,0,0, req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int addrs [9];
      void'($urandom(32'd20240611));
      m_pc = 0; m_hold = 0; m_ptr = 0; m_reen = 0;
      for (int i = 0; i < DEPTH; i++) m_stk[i] = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset address", int'(fetch_addr_o), 0);
      check("R1 reset reenable", int'(int_reenable_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: holding register zero seen through a low-byte write
      step(0,0,0,1,0,0,0,0, 'h5A,0,0, "R1 hold zero R5");
      // R12: idle holds
      idle("R12 idle");
      idle("R12 idle");
      // R6: hold write and jump in same cycle use old hold value
      step(0,1,0,0,0,0,0,1, 0,'h010,'h08, "R6 same-cycle jump R3");
      step(0,1,0,0,0,0,0,0, 0,'h010,0, "R6 next jump R3");
      // R2: wrap from top of implemented space
      step(0,1,0,0,0,0,0,0, 0,'h7FF,0, "R2 jump to top R3");
      check("R2 at top", int'(fetch_addr_o), 'hFFF);
      step(1,0,0,0,0,0,0,0, 0,0,0, "R2 wrap");
      check("R2 wrapped", int'(fetch_addr_o), 0);
      // R5: hold upper bit above implemented space wraps
      step(0,0,0,0,0,0,0,1, 0,0,'h1F, "R6 hold write");
      step(0,0,0,1,0,0,0,0, 'h33,0,0, "R5 pcl write wrap");
      check("R5 pcl value", int'(fetch_addr_o), 'hF33);
      // R4/R7: call and return
      step(0,0,1,0,0,0,0,0, 0,'h123,0, "R4 call");
      step(1,0,0,0,0,0,0,0, 0,0,0, "R2 adv in callee");
      step(0,0,0,0,1,0,0,0, 0,0,0, "R7 return");
      check("R7 return value", int'(fetch_addr_o), 'hF34);
      // R9/R10: interrupt entry and exit
      step(0,0,0,0,0,0,1,0, 0,0,0, "R9 irq entry");
      check("R9 vector", int'(fetch_addr_o), 4);
      step(1,0,0,0,0,0,0,0, 0,0,0, "R2 adv in handler");
      step(0,0,0,0,0,1,0,0, 0,0,0, "R10 reti");
      check("R10 pulse", int'(int_reenable_o), 1);
      check("R9 resume", int'(fetch_addr_o), 'hF34);
      idle("R10 pulse drops");
      check("R10 one cycle", int'(int_reenable_o), 0);
      // R11: interrupt beats return, return beats call
      step(1,1,1,1,1,1,1,0, 1,1,0, "R11 irq wins");
      step(1,1,1,1,1,0,0,0, 1,1,0, "R11 ret wins");
      step(1,1,0,1,0,0,0,0, 'h44,'h200,0, "R11 jump over pcl");
      step(1,0,0,1,0,0,0,0, 'h44,0,0, "R11 pcl over adv");
      // R8: nine calls then nine returns on the ring
      step(0,0,0,0,0,0,0,1, 0,0,0, "R6 hold clear");
      for (int k = 0; k < 9; k++) begin
         addrs[k] = (m_pc + 1) & MASK;
         step(0,0,1,0,0,0,0,0, 0,'h100 + k*16,0, "R8 call chain R4");
      end
      for (int k = 0; k < 8; k++) begin
         step(0,0,0,0,1,0,0,0, 0,0,0, "R8 unwind R7");
         check("R8 unwind order", int'(fetch_addr_o), addrs[8-k]);
      end
      step(0,0,0,0,1,0,0,0, 0,0,0, "R8 ninth pop wraps");
      check("R8 ninth pop", int'(fetch_addr_o), addrs[8]);
      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic a, j, c, p, r, ri, iq, hw;
         a  = ($urandom % 100) < 60;
         j  = ($urandom % 100) < 12;
         c  = ($urandom % 100) < 12;
         p  = ($urandom % 100) < 10;
         r  = ($urandom % 100) < 12;
         ri = ($urandom % 100) < 6;
         iq = ($urandom % 100) < 5;
         hw = ($urandom % 100) < 15;
         step(a,j,c,p,r,ri,iq,hw, int'($urandom % 256), int'($urandom % 2048),
              int'($urandom % 32), "R11 random mix R3 R4 R7");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule